// File: doc/BRIEF.md
# JTAG Instruction Decode and Data-Path Selection

This block sits behind a test access port state machine. It holds the active test instruction, decides which data register is placed between the serial input and the serial output, and drives the test-mode controls that reach the boundary-scan cells and the system reset. The state machine supplies its state levels (Update-IR, Capture-DR, Shift-DR, Update-DR, Shift-IR) and the shift-stage content of the instruction register. On each rising TCK edge taken in Update-IR, this block loads that content as the active instruction.

The core of the block is a mode state machine. Its states are MODE_BYPASS, MODE_EXTEST, MODE_SAMPLE, MODE_PRELOAD and MODE_CLAMP, and reset leaves it in MODE_BYPASS. There is one transition rule, and it applies from every state to every state. A rising TCK edge with `update_ir` high moves the machine to the state that decodes from `ir_code`. With `update_ir` low the machine stays in its current state.

The internal boundary register is an N-cell chain of parameterised length. Each cell has a shift stage and an output latch. A static strap `ext_chain_sel` hands the whole chain to external logic instead. In that case this block only forwards the external chain's serial output to TDO and leaves the internal chain untouched. TDO and its enable change on the falling TCK edge.

Top module: `jtag_path_sel`

## Requirements
- R1: While `trst_n` is low, and until a later instruction update, the mode is bypass. In that state `pin_ovr`, `sys_rst_req`, `tdo_oe`, `tdo` and `ext_bs_en` are 0 and `pin_out` is all zeros.
- R2: A new instruction takes effect only on a rising TCK edge with `update_ir` high. A change of `ir_code` without that strobe has no effect on any output.
- R3: Opcode 5'h1F (bypass), every opcode in the range 5'h10 to 5'h1E, and every other undefined opcode select the one-bit bypass register. That register loads 0 in Capture-DR and takes TDI in Shift-DR, so TDO repeats TDI one shift later. In this mode `sys_rst_req` and `pin_ovr` stay 0.
- R4: With the strap low, opcodes 5'h00 (extest), 5'h01 (sample) and 5'h02 (preload) place the internal boundary chain in the path. Capture-DR loads `pin_in`. In Shift-DR, bit 0 is presented on TDO first and TDI enters at bit N-1.
- R5: Update-DR copies the shift stages to `pin_out` under extest and preload. Under sample, Update-DR leaves `pin_out` unchanged.
- R6: Opcode 5'h09 (clamp) puts the bypass register in the path. It raises `pin_ovr`, and the boundary chain neither captures, shifts nor updates, so `pin_out` holds its last value.
- R7: `sys_rst_req` is 1 in the clamp mode and 0 in every other mode.
- R8: `pin_ovr` is 1 in the extest and clamp modes only.
- R9: With `ext_chain_sel` high, under the three boundary opcodes, TDO in Shift-DR carries `ext_bs_so` and `ext_bs_en` is 1. The internal chain and `pin_out` never change in this case.
- R10: TDO and `tdo_oe` update on the falling TCK edge. `tdo_oe` is 1 only after a falling edge taken in Shift-DR or Shift-IR, and TDO carries `ir_so` in Shift-IR. When `tdo_oe` is 0, TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| ir_code | input | 5 | Instruction register shift-stage content |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| shift_ir | input | 1 | TAP in Shift-IR |
| ir_so | input | 1 | Serial output of the instruction register |
| tdi | input | 1 | Serial test data in |
| ext_chain_sel | input | 1 | Static strap: 1 selects the external boundary chain |
| ext_bs_so | input | 1 | Serial output of the external boundary chain |
| pin_in | input | BSR_LEN | Parallel pin values for capture |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | TDO output enable |
| pin_out | output | BSR_LEN | Boundary output latches |
| pin_ovr | output | 1 | Pins driven from the boundary latches |
| sys_rst_req | output | 1 | Internal system reset request |
| ext_bs_en | output | 1 | External chain selected for the current instruction |

## Verification
The hardest situation to reach is clamp entered with latches that are not all zero. In that state the path is the bypass bit while the pins keep the boundary values, and those values must survive later capture, shift and update strobes. The bench first loads a known pattern through preload and an update. It then switches to clamp and drives capture, shifts and an update with different data. Finally it shows that TDO follows the one-bit delay and that `pin_out` did not move. The strap is handled the same way: the latches are preloaded in internal mode, then the strap is raised and a full extest sequence must leave them intact.

// File: rtl/jtag_psel_pkg.sv
package jtag_psel_pkg;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_EXTEST  = 5'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 5'h01;
    localparam logic [IR_W-1:0] OP_PRELOAD = 5'h02;
    localparam logic [IR_W-1:0] OP_CLAMP   = 5'h09;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;

    typedef enum logic [2:0] {
        MODE_BYPASS,
        MODE_EXTEST,
        MODE_SAMPLE,
        MODE_PRELOAD,
        MODE_CLAMP
    } mode_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_BSR_INT,
        PATH_BSR_EXT
    } path_e;

    // Undefined codes, including the auxiliary-access range, fall to bypass.
    function automatic mode_e decode_op(input logic [IR_W-1:0] op);
        mode_e m;
        case (op)
            OP_EXTEST:  m = MODE_EXTEST;
            OP_SAMPLE:  m = MODE_SAMPLE;
            OP_PRELOAD: m = MODE_PRELOAD;
            OP_CLAMP:   m = MODE_CLAMP;
            default:    m = MODE_BYPASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/jtag_ir_mode.sv
module jtag_ir_mode
    import jtag_psel_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            update_ir,
    input  logic [IR_W-1:0] ir_code,
    input  logic            ext_chain_sel,
    output path_e           path,
    output logic            byp_en,
    output logic            bsr_en,
    output logic            bsr_upd_en,
    output logic            ext_bs_en,
    output logic            pin_ovr,
    output logic            sys_rst_req
);

    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (update_ir) begin
            state_d = decode_op(ir_code);
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        path        = PATH_BYP;
        byp_en      = 1'b0;
        bsr_en      = 1'b0;
        bsr_upd_en  = 1'b0;
        ext_bs_en   = 1'b0;
        pin_ovr     = 1'b0;
        sys_rst_req = 1'b0;
        unique case (state_q)
            MODE_BYPASS: begin
                byp_en = 1'b1;
            end
            MODE_EXTEST: begin
                path       = ext_chain_sel ? PATH_BSR_EXT : PATH_BSR_INT;
                bsr_en     = !ext_chain_sel;
                bsr_upd_en = !ext_chain_sel;
                ext_bs_en  = ext_chain_sel;
                pin_ovr    = 1'b1;
            end
            MODE_SAMPLE: begin
                path      = ext_chain_sel ? PATH_BSR_EXT : PATH_BSR_INT;
                bsr_en    = !ext_chain_sel;
                ext_bs_en = ext_chain_sel;
            end
            MODE_PRELOAD: begin
                path       = ext_chain_sel ? PATH_BSR_EXT : PATH_BSR_INT;
                bsr_en     = !ext_chain_sel;
                bsr_upd_en = !ext_chain_sel;
                ext_bs_en  = ext_chain_sel;
            end
            MODE_CLAMP: begin
                byp_en      = 1'b1;
                pin_ovr     = 1'b1;
                sys_rst_req = 1'b1;
            end
            default: begin
                byp_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/jtag_bypass_bit.sv
module jtag_bypass_bit (
    input  logic tck,
    input  logic trst_n,
    input  logic en,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    output logic q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            q <= 1'b0;
        end else if (en && capture_dr) begin
            q <= 1'b0;
        end else if (en && shift_dr) begin
            q <= tdi;
        end
    end

endmodule

// File: rtl/jtag_bsr_chain.sv
module jtag_bsr_chain #(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           en,
    input  logic           upd_en,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           update_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] pin_in,
    output logic           so,
    output logic [LEN-1:0] pin_out
);

    localparam int TOP = LEN - 1;

    logic [LEN-1:0] stage_q;
    logic [LEN-1:0] shin;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_cell
            if (i == TOP) begin : g_head
                assign shin[i] = tdi;
            end else begin : g_body
                assign shin[i] = stage_q[i+1];
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    stage_q[i] <= 1'b0;
                end else if (en && capture_dr) begin
                    stage_q[i] <= pin_in[i];
                end else if (en && shift_dr) begin
                    stage_q[i] <= shin[i];
                end
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    pin_out[i] <= 1'b0;
                end else if (upd_en && update_dr) begin
                    pin_out[i] <= stage_q[i];
                end
            end
        end
    endgenerate

    assign so = stage_q[0];

endmodule

// File: rtl/jtag_tdo_out.sv
module jtag_tdo_out (
    input  logic tck,
    input  logic trst_n,
    input  logic shift_ir,
    input  logic shift_dr,
    input  logic ir_so,
    input  logic dr_so,
    output logic tdo,
    output logic tdo_oe
);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_ir | shift_dr;
            if (shift_ir) begin
                tdo <= ir_so;
            end else if (shift_dr) begin
                tdo <= dr_so;
            end else begin
                tdo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/jtag_path_sel.sv
module jtag_path_sel
    import jtag_psel_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic [IR_W-1:0]    ir_code,
    input  logic               update_ir,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               shift_ir,
    input  logic               ir_so,
    input  logic               tdi,
    input  logic               ext_chain_sel,
    input  logic               ext_bs_so,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               pin_ovr,
    output logic               sys_rst_req,
    output logic               ext_bs_en
);

    path_e path;
    logic  byp_en, bsr_en, bsr_upd_en;
    logic  byp_q, bsr_so, dr_so;

    jtag_ir_mode u_mode (
        .tck          (tck),
        .trst_n       (trst_n),
        .update_ir    (update_ir),
        .ir_code      (ir_code),
        .ext_chain_sel(ext_chain_sel),
        .path         (path),
        .byp_en       (byp_en),
        .bsr_en       (bsr_en),
        .bsr_upd_en   (bsr_upd_en),
        .ext_bs_en    (ext_bs_en),
        .pin_ovr      (pin_ovr),
        .sys_rst_req  (sys_rst_req)
    );

    jtag_bypass_bit u_byp (
        .tck       (tck),
        .trst_n    (trst_n),
        .en        (byp_en),
        .capture_dr(capture_dr),
        .shift_dr  (shift_dr),
        .tdi       (tdi),
        .q         (byp_q)
    );

    jtag_bsr_chain #(.LEN(BSR_LEN)) u_bsr (
        .tck       (tck),
        .trst_n    (trst_n),
        .en        (bsr_en),
        .upd_en    (bsr_upd_en),
        .capture_dr(capture_dr),
        .shift_dr  (shift_dr),
        .update_dr (update_dr),
        .tdi       (tdi),
        .pin_in    (pin_in),
        .so        (bsr_so),
        .pin_out   (pin_out)
    );

    always_comb begin
        unique case (path)
            PATH_BSR_INT: dr_so = bsr_so;
            PATH_BSR_EXT: dr_so = ext_bs_so;
            default:      dr_so = byp_q;
        endcase
    end

    jtag_tdo_out u_tdo (
        .tck     (tck),
        .trst_n  (trst_n),
        .shift_ir(shift_ir),
        .shift_dr(shift_dr),
        .ir_so   (ir_so),
        .dr_so   (dr_so),
        .tdo     (tdo),
        .tdo_oe  (tdo_oe)
    );

endmodule

// File: rtl/jtag_path_sel_chk.sv
module jtag_path_sel_chk
    import jtag_psel_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               trst_n,
    input logic [IR_W-1:0]    ir_code,
    input logic               update_ir,
    input logic               update_dr,
    input logic               shift_dr,
    input logic               shift_ir,
    input logic               ext_chain_sel,
    input logic               tdo,
    input logic               tdo_oe,
    input logic [BSR_LEN-1:0] pin_out,
    input logic               pin_ovr,
    input logic               sys_rst_req
);

    assert_hold_mode_R2: assert property (@(posedge tck) disable iff (!trst_n)
        !update_ir |=> ($stable(pin_ovr) && $stable(sys_rst_req)));

    assert_bypass_quiet_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (update_ir && ir_code == OP_BYPASS) |=> (!sys_rst_req && !pin_ovr));

    assert_latch_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
        !update_dr |=> $stable(pin_out));

    assert_clamp_ovr_R6: assert property (@(posedge tck) disable iff (!trst_n)
        sys_rst_req |-> pin_ovr);

    assert_clamp_rst_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (update_ir && ir_code == OP_CLAMP) |=> sys_rst_req);

    assert_ext_untouched_R9: assert property (@(posedge tck) disable iff (!trst_n)
        ext_chain_sel |=> $stable(pin_out));

    assert_oe_on_R10: assert property (@(negedge tck) disable iff (!trst_n)
        (shift_dr || shift_ir) |=> tdo_oe);

    assert_oe_off_R10: assert property (@(negedge tck) disable iff (!trst_n)
        !(shift_dr || shift_ir) |=> (!tdo_oe && !tdo));

endmodule

bind jtag_path_sel jtag_path_sel_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .ir_code      (ir_code),
    .update_ir    (update_ir),
    .update_dr    (update_dr),
    .shift_dr     (shift_dr),
    .shift_ir     (shift_ir),
    .ext_chain_sel(ext_chain_sel),
    .tdo          (tdo),
    .tdo_oe       (tdo_oe),
    .pin_out      (pin_out),
    .pin_ovr      (pin_ovr),
    .sys_rst_req  (sys_rst_req)
);

// File: tb/sim_jtag_path_sel.sv
module sim_jtag_path_sel;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic [4:0]   ir_code = 5'h1F;
    logic         update_ir = 1'b0;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic         shift_ir = 1'b0;
    logic         ir_so = 1'b0;
    logic         tdi = 1'b0;
    logic         ext_chain_sel = 1'b0;
    logic         ext_bs_so = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         tdo, tdo_oe, pin_ovr, sys_rst_req, ext_bs_en;
    logic [N-1:0] pin_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) tck = ~tck;

    jtag_path_sel #(.BSR_LEN(N)) u0 (
        .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .shift_ir(shift_ir), .ir_so(ir_so), .tdi(tdi),
        .ext_chain_sel(ext_chain_sel), .ext_bs_so(ext_bs_so), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .pin_ovr(pin_ovr),
        .sys_rst_req(sys_rst_req), .ext_bs_en(ext_bs_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [4:0] op);
        ir_code = op;
        update_ir = 1'b1;
        cyc();
        update_ir = 1'b0;
    endtask

    task automatic capture();
        capture_dr = 1'b1;
        cyc();
        capture_dr = 1'b0;
    endtask

    task automatic update();
        update_dr = 1'b1;
        cyc();
        update_dr = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] din, input int n, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            shift_dr = 1'b1;
            tdi = din[i];
            cyc();
            dout[i] = tdo;
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 pin_ovr", pin_ovr, 0);
        chk("R1 sys_rst_req", sys_rst_req, 0);
        chk("R1 tdo_oe", tdo_oe, 0);
        chk("R1 tdo", tdo, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 ext_bs_en", ext_bs_en, 0);
    endtask

    task automatic test_update_gate();
        ir_code = 5'h09;
        cyc(); cyc();
        chk("R2 no update: pin_ovr", pin_ovr, 0);
        chk("R2 no update: sys_rst_req", sys_rst_req, 0);
        load_ir(5'h09);
        chk("R2 after update: sys_rst_req", sys_rst_req, 1);
        load_ir(5'h1F);
        chk("R2 back to bypass", sys_rst_req, 0);
    endtask

    task automatic test_bypass(input logic [4:0] op, input logic [31:0] d);
        logic [31:0] o;
        load_ir(op);
        chk("R3 no reset", sys_rst_req, 0);
        chk("R3 no override", pin_ovr, 0);
        capture();
        shift_bits(d, 8, o);
        chk("R3 one-bit delay", o & 32'hFF, (d << 1) & 32'hFF);
    endtask

    task automatic test_boundary_load(input logic [4:0] op, input logic [7:0] p,
                                      input logic [7:0] d, input logic [7:0] exp_pins);
        logic [31:0] o;
        load_ir(op);
        pin_in = p;
        capture();
        shift_bits({24'h0, d}, N, o);
        chk("R4 captured pins on tdo", o[7:0], p);
        update();
        chk("R5 latch after update", pin_out, exp_pins);
    endtask

    task automatic test_extest_ovr();
        load_ir(5'h00);
        chk("R8 extest override", pin_ovr, 1);
        chk("R7 extest no reset", sys_rst_req, 0);
        load_ir(5'h01);
        chk("R8 sample no override", pin_ovr, 0);
        load_ir(5'h02);
        chk("R8 preload no override", pin_ovr, 0);
    endtask

    task automatic test_clamp(input logic [31:0] d);
        logic [31:0] o;
        logic [N-1:0] held;
        held = pin_out;
        load_ir(5'h09);
        chk("R6 clamp override", pin_ovr, 1);
        chk("R7 clamp reset", sys_rst_req, 1);
        pin_in = ~held;
        capture();
        shift_bits(d, 8, o);
        chk("R6 clamp bypass path", o & 32'hFF, (d << 1) & 32'hFF);
        update();
        chk("R6 clamp pins held", pin_out, held);
    endtask

    task automatic test_ext_chain();
        logic [N-1:0] held;
        held = pin_out;
        load_ir(5'h1F);
        ext_chain_sel = 1'b1;
        load_ir(5'h00);
        chk("R9 ext enable", ext_bs_en, 1);
        pin_in = ~held;
        capture();
        for (int i = 0; i < 4; i++) begin
            shift_dr = 1'b1;
            tdi = 1'b1;
            ext_bs_so = i[0];
            cyc();
            chk("R9 tdo from external", tdo, i[0]);
        end
        shift_dr = 1'b0;
        update();
        chk("R9 internal latches untouched", pin_out, held);
        load_ir(5'h1F);
        chk("R9 ext enable off in bypass", ext_bs_en, 0);
        ext_chain_sel = 1'b0;
        ext_bs_so = 1'b0;
    endtask

    task automatic test_tdo_edge();
        shift_ir = 1'b1;
        ir_so = 1'b1;
        #2;
        chk("R10 tdo waits for falling edge", tdo, 0);
        cyc();
        chk("R10 tdo from ir", tdo, 1);
        chk("R10 oe in shift-ir", tdo_oe, 1);
        shift_ir = 1'b0;
        ir_so = 1'b0;
        cyc();
        chk("R10 oe off", tdo_oe, 0);
        chk("R10 tdo zero when off", tdo, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        test_reset();
        trst_n = 1'b1;
        cyc();
        test_reset();
        test_update_gate();
        test_bypass(5'h1F, 32'hB5);
        test_bypass(5'h11, 32'h6C);
        test_bypass(5'h07, 32'h93);
        test_extest_ovr();
        test_boundary_load(5'h02, 8'hA3, 8'h5E, 8'h5E);
        test_boundary_load(5'h01, 8'h3C, 8'hF0, 8'h5E);
        test_boundary_load(5'h00, 8'hC9, 8'h27, 8'h27);
        test_clamp(32'hD2);
        test_ext_chain();
        test_tdo_edge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule